// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt request lines and drives the two interrupt inputs of a processor: a fast request (`fiq_o`) and a normal request (`irq_o`). Each line can be steered to the fast or the normal class and enabled on its own. Software can also raise any line by setting a bit in a soft-request register. The value used inside the block for each line is the hardware line ORed with its soft bit.

Every line has a vector slot that holds a handler address and a priority from 0 (most urgent) to 15 (least urgent). The block looks up the most urgent normal-class request and returns its handler address when software reads the active-vector register. That read records the winner's priority level as in service. From then on only strictly more urgent requests raise `irq_o`. Any write to the active-vector register ends the most recent service level. A request that was held back is then presented again. All control and status state is reached through a simple word-addressed register port, and read data is registered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The effective request of line n is `src_irq_i[n]` OR soft bit n. A read of index 0x00 returns all effective requests, whatever their enable or class.
- R2: Class register (index 0x03, read/write): bit value 1 sends the line to the fast class and 0 sends it to the normal class. `fiq_o` is high exactly when some enabled fast-class request is active. Index 0x01 reads the enabled fast-class requests and index 0x02 reads the enabled normal-class requests.
- R3: A write to index 0x04 sets the enable bits where the data holds 1s and leaves the other bits unchanged; a read of 0x04 returns the enables. A write to index 0x05 clears the enable bits where the data holds 1s.
- R4: A write to index 0x06 sets soft bits where the data holds 1s; a read of 0x06 returns them. A write to index 0x07 clears soft bits where the data holds 1s.
- R5: The priority of slot n is at index 0x40+n, in bits 3:0 (read/write). Every priority resets to 15. The handler address of slot n is at index 0x20+n. A lower number is more urgent.
- R6: `irq_o` is high exactly when an enabled normal-class request is active whose priority is numerically below the innermost in-service level. With no level in service, any such request raises `irq_o`.
- R7: A read of index 0x08 while `irq_o` is high returns the handler address of the winner. The winner is the request with the lowest priority number; among equal numbers the lowest slot number wins. Read data appears on `rdata_o` in the cycle after `rd_en_i`.
- R8: A read of 0x08 that returns a winner puts that winner's priority in service. Requests of equal or less urgent priority are then held off `irq_o`.
- R9: Any write to index 0x08 takes the innermost level out of service. A held-back request then raises `irq_o` again.
- R10: A read of 0x08 while `irq_o` is low returns 0 and does not change the in-service state.
- R11: After reset, the enable, class and soft registers read 0, no level is in service, and both `fiq_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_irq_i | input | 32 | Level-sensitive hardware request lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 7 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| fiq_o | output | 1 | Fast interrupt request to the processor |
| irq_o | output | 1 | Normal interrupt request to the processor |

## Verification
The hardest state to reach from the ports is two nested service levels, one above the other, followed by their unwinding. In that state a pending request sits at the same level as an outer service and must stay hidden until its own level is taken out of service. The stimulus builds this state in steps. It first takes one of two tied priority-5 lines, then raises a priority-2 line and takes it as well. It drops that line and ends service twice, checking `irq_o` and the vector read after each step.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
   localparam int REG_AW   = 7;
   localparam int REG_DW   = 32;

   localparam logic [REG_AW-1:0] IDX_RAW    = 7'h00;
   localparam logic [REG_AW-1:0] IDX_FSTAT  = 7'h01;
   localparam logic [REG_AW-1:0] IDX_NSTAT  = 7'h02;
   localparam logic [REG_AW-1:0] IDX_CLASS  = 7'h03;
   localparam logic [REG_AW-1:0] IDX_ENSET  = 7'h04;
   localparam logic [REG_AW-1:0] IDX_ENCLR  = 7'h05;
   localparam logic [REG_AW-1:0] IDX_SWSET  = 7'h06;
   localparam logic [REG_AW-1:0] IDX_SWCLR  = 7'h07;
   localparam logic [REG_AW-1:0] IDX_ACTIVE = 7'h08;

   localparam logic [1:0] WIN_VEC = 2'b01;
   localparam logic [1:0] WIN_PRI = 2'b10;
endpackage

// File: rtl/irq_src_route.sv
module irq_src_route #(
   parameter int NSRC = 32
) (
   input  logic [NSRC-1:0] hw_i,
   input  logic [NSRC-1:0] soft_i,
   input  logic [NSRC-1:0] en_i,
   input  logic [NSRC-1:0] fast_sel_i,
   output logic [NSRC-1:0] eff_o,
   output logic [NSRC-1:0] fast_act_o,
   output logic [NSRC-1:0] norm_act_o,
   output logic            fast_any_o
);
   always_comb begin
      eff_o      = hw_i | soft_i;
      fast_act_o = eff_o & en_i & fast_sel_i;
      norm_act_o = eff_o & en_i & ~fast_sel_i;
      fast_any_o = |fast_act_o;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NSRC = 32,
   parameter int PW   = 4,
   localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NSRC-1:0]    req_i,
   input  logic [NSRC*PW-1:0] prio_i,
   input  logic [PW:0]        ceiling_i,
   output logic               valid_o,
   output logic [IW-1:0]      idx_o,
   output logic [PW-1:0]      prio_o
);
   logic [PW:0] best;

   always_comb begin
      best    = ceiling_i;
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (req_i[i] && ({1'b0, prio_i[i*PW +: PW]} < best)) begin
            best    = {1'b0, prio_i[i*PW +: PW]};
            valid_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
      prio_o = best[PW-1:0];
   end

   // R7: a reported winner is a live request below the ceiling
   a_r7_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (req_i[idx_o] && ({1'b0, prio_i[idx_o*PW +: PW]} < ceiling_i)));
endmodule

// File: rtl/irq_nest_levels.sv
module irq_nest_levels #(
   parameter int PW   = 4,
   localparam int NLV = 1 << PW
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          push_i,
   input  logic [PW-1:0] push_lvl_i,
   input  logic          pop_i,
   output logic [PW:0]   ceiling_o
);
   logic [NLV-1:0] inserv_q, inserv_d, popped;

   always_comb begin
      popped = pop_i ? (inserv_q & (inserv_q - NLV'(1))) : inserv_q;
      inserv_d = popped;
      if (push_i) inserv_d[push_lvl_i] = 1'b1;
   end

   always_comb begin
      ceiling_o = (PW+1)'(NLV);
      for (int l = NLV - 1; l >= 0; l--) begin
         if (inserv_q[l]) ceiling_o = (PW+1)'(l);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) inserv_q <= '0;
      else         inserv_q <= inserv_d;
   end

   // R8: a push without a pop makes the pushed level the innermost one
   a_r8_push_sets_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i) |=> (ceiling_o == {1'b0, $past(push_lvl_i)}));
   // R9: a pop without a push removes exactly one level when one is held
   a_r9_pop_one_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !push_i && (inserv_q != '0)) |=>
         ($countones(inserv_q) == $countones($past(inserv_q)) - 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vector_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int PW    = 4,
   parameter int VEC_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   src_irq_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [REG_DW-1:0] wdata_i,
   output logic [REG_DW-1:0] rdata_o,
   output logic              fiq_o,
   output logic              irq_o
);
   localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NSRC < 2 || NSRC > 32) begin : g_bad_nsrc
      $error("NSRC must be 2..32");
   end
   if (PW < 1 || PW > 4) begin : g_bad_pw
      $error("PW must be 1..4");
   end
   if (VEC_W < 1 || VEC_W > REG_DW) begin : g_bad_vec
      $error("VEC_W must fit the data word");
   end

   logic [NSRC-1:0]   en_q, sel_q, soft_q;
   logic [VEC_W-1:0]  vec_q [NSRC];
   logic [PW-1:0]     pri_q [NSRC];
   logic [NSRC*PW-1:0] pri_flat;

   logic [NSRC-1:0] eff, fast_act, norm_act;
   logic            fast_any;
   logic            pick_valid;
   logic [IW-1:0]   pick_idx;
   logic [PW-1:0]   pick_prio;
   logic [PW:0]     ceiling;

   logic [1:0]      win;
   logic [4:0]      slot_raw;
   logic [IW-1:0]   slot;
   logic            slot_ok;
   logic            act_rd, act_wr;

   assign win      = addr_i[6:5];
   assign slot_raw = addr_i[4:0];
   assign slot     = addr_i[IW-1:0];
   assign slot_ok  = (32'(slot_raw) < NSRC);
   assign act_rd   = rd_en_i && (addr_i == IDX_ACTIVE);
   assign act_wr   = wr_en_i && (addr_i == IDX_ACTIVE);

   for (genvar g = 0; g < NSRC; g++) begin : g_slot
      assign pri_flat[g*PW +: PW] = pri_q[g];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vec_q[g] <= '0;
            pri_q[g] <= '1;
         end else if (wr_en_i && slot_ok && (32'(slot_raw) == g)) begin
            if (win == WIN_VEC) vec_q[g] <= wdata_i[VEC_W-1:0];
            if (win == WIN_PRI) pri_q[g] <= wdata_i[PW-1:0];
         end
      end
   end

   irq_src_route #(.NSRC(NSRC)) u_route (
      .hw_i       (src_irq_i),
      .soft_i     (soft_q),
      .en_i       (en_q),
      .fast_sel_i (sel_q),
      .eff_o      (eff),
      .fast_act_o (fast_act),
      .norm_act_o (norm_act),
      .fast_any_o (fast_any)
   );

   irq_prio_pick #(.NSRC(NSRC), .PW(PW)) u_pick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (norm_act),
      .prio_i    (pri_flat),
      .ceiling_i (ceiling),
      .valid_o   (pick_valid),
      .idx_o     (pick_idx),
      .prio_o    (pick_prio)
   );

   irq_nest_levels #(.PW(PW)) u_nest (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (act_rd && pick_valid),
      .push_lvl_i (pick_prio),
      .pop_i      (act_wr),
      .ceiling_o  (ceiling)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         sel_q  <= '0;
         soft_q <= '0;
      end else if (wr_en_i) begin
         unique case (addr_i)
            IDX_CLASS: sel_q  <= wdata_i[NSRC-1:0];
            IDX_ENSET: en_q   <= en_q | wdata_i[NSRC-1:0];
            IDX_ENCLR: en_q   <= en_q & ~wdata_i[NSRC-1:0];
            IDX_SWSET: soft_q <= soft_q | wdata_i[NSRC-1:0];
            IDX_SWCLR: soft_q <= soft_q & ~wdata_i[NSRC-1:0];
            default: ;
         endcase
      end
   end

   logic [REG_DW-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (win == WIN_VEC) begin
         if (slot_ok) rd_val = REG_DW'(vec_q[slot]);
      end else if (win == WIN_PRI) begin
         if (slot_ok) rd_val = REG_DW'(pri_q[slot]);
      end else begin
         case (addr_i)
            IDX_RAW:    rd_val = REG_DW'(eff);
            IDX_FSTAT:  rd_val = REG_DW'(fast_act);
            IDX_NSTAT:  rd_val = REG_DW'(norm_act);
            IDX_CLASS:  rd_val = REG_DW'(sel_q);
            IDX_ENSET:  rd_val = REG_DW'(en_q);
            IDX_SWSET:  rd_val = REG_DW'(soft_q);
            IDX_ACTIVE: rd_val = pick_valid ? REG_DW'(vec_q[pick_idx]) : '0;
            default:    rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_val;
   end

   assign fiq_o = fast_any;
   assign irq_o = pick_valid;

   // R6: the request line only rises for a winner above the innermost level
   a_r6_irq_above_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ({1'b0, pick_prio} < ceiling));
   // R3: bits written to the clear index are gone one cycle later
   a_r3_enable_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == IDX_ENCLR) |=> ((en_q & $past(wdata_i[NSRC-1:0])) == '0));
   // R10: a read of the active index with nothing pending leaves the ceiling alone
   a_r10_empty_read_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_rd && !pick_valid && !wr_en_i) |=> $stable(ceiling));
   // R2: the fast request never rises for a line that is neither enabled nor fast-class
   a_r2_fiq_needs_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fiq_o |-> ((sel_q & en_q) != '0));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fiq, irq;

   int n_chk = 0, n_fail = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sbq[$];
   logic rd_seen = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl dut (
      .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
   );

   always @(posedge clk) rd_seen <= rd_en;

   // monitor: compare registered read data with queued expectations
   always @(negedge clk) begin
      if (rd_seen && sbq.size() > 0) begin
         sb_item_t it;
         it = sbq.pop_front();
         n_chk++;
         if (rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      it.exp = e; it.tag = tag;
      sbq.push_back(it);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(input logic act, input logic e, input string tag);
      n_chk++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: got=%b expected=%b", tag, act, e);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(irq, 1'b0, "R11 irq after reset");
      chk(fiq, 1'b0, "R11 fiq after reset");
      rd(7'h04, 32'h0, "R11 enable reset");
      rd(7'h03, 32'h0, "R11 class reset");
      rd(7'h45, 32'hF, "R5 priority resets to 15");
      rd(7'h08, 32'h0, "R10 active read with nothing pending");

      // R1 raw status and soft requests
      src = 32'h8;
      @(negedge clk);
      rd(7'h00, 32'h8, "R1 raw shows hw line");
      wr(7'h06, 32'h400);
      rd(7'h00, 32'h408, "R1 raw ORs soft bit");
      rd(7'h06, 32'h400, "R4 soft set readback");
      wr(7'h07, 32'h400);
      rd(7'h00, 32'h8, "R4 soft clear");

      // R3 enable set-only and clear
      wr(7'h04, 32'h8);
      wr(7'h04, 32'h1);
      rd(7'h04, 32'h9, "R3 enable writes only set");
      wr(7'h05, 32'h1);
      rd(7'h04, 32'h8, "R3 enable clear");

      // R2 class routing
      wr(7'h03, 32'h8);
      chk(fiq, 1'b1, "R2 fiq for fast-class line");
      chk(irq, 1'b0, "R2 no irq for fast-class line");
      rd(7'h01, 32'h8, "R2 fast status");
      rd(7'h02, 32'h0, "R2 normal status empty");
      wr(7'h03, 32'h0);
      chk(fiq, 1'b0, "R2 fiq drops after reclass");
      chk(irq, 1'b1, "R6 irq for normal-class line");
      rd(7'h02, 32'h8, "R2 normal status");

      // R5/R7 vectors and priorities
      wr(7'h23, 32'hA000_0300);
      wr(7'h27, 32'hA000_0700);
      wr(7'h29, 32'hA000_0900);
      wr(7'h43, 32'h5);
      wr(7'h47, 32'h5);
      wr(7'h49, 32'hF2);
      rd(7'h49, 32'h2, "R5 priority field width");
      wr(7'h04, 32'h288);
      src = 32'h88;
      @(negedge clk);
      rd(7'h08, 32'hA000_0300, "R7 tie goes to lowest slot");
      chk(irq, 1'b0, "R8 equal level held off");
      src = 32'h288;
      @(negedge clk);
      chk(irq, 1'b1, "R8 more urgent request passes");
      rd(7'h08, 32'hA000_0900, "R7 most urgent wins");
      chk(irq, 1'b0, "R8 nested level masks");
      src = 32'h88;
      @(negedge clk);
      wr(7'h08, 32'h0);
      chk(irq, 1'b0, "R9 outer level still masks");
      wr(7'h08, 32'h0);
      chk(irq, 1'b1, "R9 pending request returns after end of service");
      rd(7'h08, 32'hA000_0300, "R7 vector after unwind");
      wr(7'h08, 32'h0);

      // R10 empty read does not enter a level
      src = 32'h0;
      @(negedge clk);
      rd(7'h08, 32'h0, "R10 empty active read returns 0");
      src = 32'h200;
      @(negedge clk);
      chk(irq, 1'b1, "R10 no level entered by empty read");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule